// File: doc/BRIEF.md
# Procedure Call Frame Sequencer

This block performs the memory side of a mask-driven procedure call and of the matching return. For a call it is given the argument count, the target address and a 16-bit save mask taken from the callee's entry word. It then builds a frame on a descending stack and updates the four pointer registers: argument pointer (register 12), frame pointer (register 13), stack pointer (register 14) and program counter (register 15). For a return it takes the frame apart again. Every push lowers the stack pointer by 4 and then writes the word at the new address. Every pop reads at the stack pointer and then raises it by 4.

The block owns one single-word memory port and one register-file port with a combinational read and a single write. It makes one memory access at a time and holds each request until the memory acknowledges it. The state machine has these states. IDLE waits and latches the start operands. Call states: C_ARGC pushes the count, C_REGS pushes the masked registers, then C_PC, C_FP, C_AP and C_MASK push the old pointers and the mask word. C_SETFP, C_SETSP, C_SETAP and C_SETPC write the new pointers. Return states: R_MASK pops the mask; R_AP, R_FP and R_PC pop and restore the pointers; R_REGS restores the masked registers; R_ARGC pops the argument count and discards the argument list; R_SETSP writes the final stack pointer.

Transitions: IDLE goes to C_ARGC on a call start, or to R_MASK on a return start. C_ARGC goes to C_REGS, or straight to C_PC when the effective mask is empty. C_REGS stays while mask bits remain. The call then steps through C_PC to C_SETPC and back to IDLE. On return, R_PC goes to R_REGS, or to R_ARGC when the mask is empty. R_ARGC goes to R_SETSP, and R_SETSP goes back to IDLE. Every state that makes a memory access waits in place until the acknowledge arrives.

Top module: `frame_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, busy, done, mem_req and rf_we are all low.
- R2: A call first pushes the argument count, zero-extended, at SP-4, and the new argument pointer (register 12) becomes that address.
- R3: A call then pushes each selected register from the highest index to the lowest. Each push is at 4 below the previous one, and bit i of the mask selects register i.
- R4: After the registers, a call pushes the old PC, old FP and old AP, in that order. It then pushes the mask word, which holds the effective mask in bits 15:0 with zeros above.
- R5: Mask bits 12 to 15 are treated as zero. They neither save a register nor appear in the stored mask word.
- R6: At the end of a call, FP and SP both equal the address of the mask word, and PC equals the target address plus 2.
- R7: A return loads its working stack address from FP. It pops the mask word, then the AP, FP and PC values, then the masked registers from lowest index to highest, and writes each popped value back to its register.
- R8: During a return, registers whose effective mask bit is clear keep their current value.
- R9: A return ends with SP equal to the address of the argument-count word plus 4 plus 4 times that count.
- R10: Only one memory access is in flight at a time. mem_req, mem_we and mem_addr hold steady until mem_ack, so a call with n selected registers makes exactly n+5 accesses, and so does the matching return.
- R11: busy is high from the cycle after a start until the last cycle of the operation. done is high for exactly that last cycle. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_go | input | 1 | Start a call sequence (takes priority over ret_go) |
| ret_go | input | 1 | Start a return sequence |
| call_argc | input | ARGC_W | Argument count of the call |
| call_target | input | DW | Address of the callee's entry word |
| entry_mask | input | NREG | Register-save mask from the callee's entry word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last cycle of a sequence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid while mem_ack is high |
| mem_ack | input | 1 | Access completes this cycle |
| rf_raddr | output | log2(NREG) | Register-file read index |
| rf_rdata | input | DW | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | log2(NREG) | Register-file write index |
| rf_wdata | output | DW | Register-file write data |

## Verification
The bench sweeps 70 masks, including the empty mask, the full mask, a mask with only bits 12 to 15 set, and single-bit masks at both ends. It pairs each mask with argument counts from 0 to 5 and with memory stalls of 0 to 2 cycles, and runs each call followed by its return. A design that scanned the mask in the wrong direction would store the saved registers in reverse order and would restore the wrong values. A design that let the pointer bits through the mask would grow the frame by up to four words and would misplace every later slot. A design that got the argument-discard arithmetic wrong would leave SP off by a multiple of 4 after the return, and this shows up most clearly with a count of zero. Some runs fire the opposite start in the middle of a sequence; a design that acted on it would corrupt the frame or change the access count. Registers left out of the mask are corrupted before each return, so a design that wrote them back would be caught.

// File: rtl/frame_pkg.sv
`timescale 1ns/1ps
package frame_pkg;

    typedef enum logic [4:0] {
        IDLE,
        C_ARGC, C_REGS, C_PC, C_FP, C_AP, C_MASK,
        C_SETFP, C_SETSP, C_SETAP, C_SETPC,
        R_MASK, R_AP, R_FP, R_PC, R_REGS, R_ARGC, R_SETSP
    } seq_state_t;

    typedef enum logic [2:0] {
        SP_HOLD, SP_LOAD, SP_PUSH, SP_POP, SP_ADD
    } sp_op_t;

    localparam int REG_AP = 12;
    localparam int REG_FP = 13;
    localparam int REG_SP = 14;
    localparam int REG_PC = 15;
    localparam int PC_ENTRY_SKIP = 2;

endpackage

// File: rtl/mask_pick.sv
`timescale 1ns/1ps
module mask_pick #(
    parameter int W          = 16,
    parameter bit HIGH_FIRST = 1'b1,
    localparam int IW        = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);

    assign any = |mask;

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end
    endgenerate

    always_comb begin
        onehot      = '0;
        onehot[idx] = any;
    end

endmodule

// File: rtl/stack_ptr.sv
`timescale 1ns/1ps
module stack_ptr
    import frame_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_op_t        op,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] add_val,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] below
);

    localparam logic [DW-1:0] WORD_BYTES = DW'(4);

    assign below = sp - WORD_BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else begin
            unique case (op)
                SP_LOAD: sp <= load_val;
                SP_PUSH: sp <= below;
                SP_POP:  sp <= sp + WORD_BYTES;
                SP_ADD:  sp <= sp + add_val;
                default: sp <= sp;
            endcase
        end
    end

endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
    import frame_pkg::*;
#(
    parameter int DW         = 32,
    parameter int NREG       = 16,
    parameter int ARGC_W     = 8,
    parameter int SAVE_LIMIT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    call_go,
    input  logic                    ret_go,
    input  logic [ARGC_W-1:0]       call_argc,
    input  logic [DW-1:0]           call_target,
    input  logic [NREG-1:0]         entry_mask,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [DW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ack,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [DW-1:0]           rf_rdata,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [DW-1:0]           rf_wdata
);

    localparam int RIW = $clog2(NREG);
    localparam logic [NREG-1:0] SAVE_MASK = NREG'((1 << SAVE_LIMIT) - 1);
    localparam logic [RIW-1:0] I_AP = RIW'(REG_AP);
    localparam logic [RIW-1:0] I_FP = RIW'(REG_FP);
    localparam logic [RIW-1:0] I_SP = RIW'(REG_SP);
    localparam logic [RIW-1:0] I_PC = RIW'(REG_PC);

    seq_state_t state, state_nx;

    logic [NREG-1:0]   mask_q, work_q;
    logic [ARGC_W-1:0] argc_q;
    logic [DW-1:0]     target_q, apn_q;

    sp_op_t        sp_op;
    logic [DW-1:0] sp_load, sp_add, sp, sp_below;

    logic            hi_any, lo_any;
    logic [RIW-1:0]  hi_idx, lo_idx;
    logic [NREG-1:0] hi_oh, lo_oh;

    logic          acked;
    logic [DW-1:0] popped_argc_bytes;
    logic          rem_after_hi, rem_after_lo;

    mask_pick #(.W(NREG), .HIGH_FIRST(1'b1)) u_pick_hi (
        .mask(work_q), .any(hi_any), .idx(hi_idx), .onehot(hi_oh)
    );

    mask_pick #(.W(NREG), .HIGH_FIRST(1'b0)) u_pick_lo (
        .mask(work_q), .any(lo_any), .idx(lo_idx), .onehot(lo_oh)
    );

    stack_ptr #(.DW(DW)) u_sp (
        .clk(clk), .rst_n(rst_n), .op(sp_op),
        .load_val(sp_load), .add_val(sp_add),
        .sp(sp), .below(sp_below)
    );

    assign acked             = mem_req && mem_ack;
    assign popped_argc_bytes = DW'(mem_rdata[ARGC_W-1:0]) << 2;
    assign rem_after_hi      = |(work_q & ~hi_oh);
    assign rem_after_lo      = |(work_q & ~lo_oh);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:    if (call_go) state_nx = C_ARGC;
                     else if (ret_go) state_nx = R_MASK;
            C_ARGC:  if (acked) state_nx = ((mask_q & SAVE_MASK) != '0) ? C_REGS : C_PC;
            C_REGS:  if (acked && !rem_after_hi) state_nx = C_PC;
            C_PC:    if (acked) state_nx = C_FP;
            C_FP:    if (acked) state_nx = C_AP;
            C_AP:    if (acked) state_nx = C_MASK;
            C_MASK:  if (acked) state_nx = C_SETFP;
            C_SETFP: state_nx = C_SETSP;
            C_SETSP: state_nx = C_SETAP;
            C_SETAP: state_nx = C_SETPC;
            C_SETPC: state_nx = IDLE;
            R_MASK:  if (acked) state_nx = R_AP;
            R_AP:    if (acked) state_nx = R_FP;
            R_FP:    if (acked) state_nx = R_PC;
            R_PC:    if (acked) state_nx = (work_q != '0) ? R_REGS : R_ARGC;
            R_REGS:  if (acked && !rem_after_lo) state_nx = R_ARGC;
            R_ARGC:  if (acked) state_nx = R_SETSP;
            R_SETSP: state_nx = IDLE;
            default: state_nx = IDLE;
        endcase
    end

    // latched operands and working mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            work_q   <= '0;
            argc_q   <= '0;
            target_q <= '0;
            apn_q    <= '0;
        end else begin
            if (state == IDLE && call_go) begin
                mask_q   <= entry_mask & SAVE_MASK;
                work_q   <= entry_mask & SAVE_MASK;
                argc_q   <= call_argc;
                target_q <= call_target;
            end
            if (state == C_ARGC && acked) apn_q <= sp_below;
            if (state == C_REGS && acked) work_q <= work_q & ~hi_oh;
            if (state == R_MASK && acked) work_q <= mem_rdata[NREG-1:0] & SAVE_MASK;
            if (state == R_REGS && acked) work_q <= work_q & ~lo_oh;
        end
    end

    // stack pointer control
    always_comb begin
        sp_op   = SP_HOLD;
        sp_load = rf_rdata;
        sp_add  = DW'(4) + popped_argc_bytes;
        unique case (state)
            IDLE: if (call_go || ret_go) sp_op = SP_LOAD;
            C_ARGC, C_REGS, C_PC, C_FP, C_AP, C_MASK:
                if (acked) sp_op = SP_PUSH;
            R_MASK, R_AP, R_FP, R_PC, R_REGS:
                if (acked) sp_op = SP_POP;
            R_ARGC: if (acked) sp_op = SP_ADD;
            default: sp_op = SP_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != IDLE);
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_below;
        mem_wdata = rf_rdata;
        rf_raddr  = I_SP;
        rf_we     = 1'b0;
        rf_waddr  = I_SP;
        rf_wdata  = sp;
        unique case (state)
            IDLE:    rf_raddr = (ret_go && !call_go) ? I_FP : I_SP;
            C_ARGC:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = DW'(argc_q); end
            C_REGS:  begin mem_req = 1'b1; mem_we = 1'b1; rf_raddr = hi_idx; end
            C_PC:    begin mem_req = 1'b1; mem_we = 1'b1; rf_raddr = I_PC; end
            C_FP:    begin mem_req = 1'b1; mem_we = 1'b1; rf_raddr = I_FP; end
            C_AP:    begin mem_req = 1'b1; mem_we = 1'b1; rf_raddr = I_AP; end
            C_MASK:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = DW'(mask_q); end
            C_SETFP: begin rf_we = 1'b1; rf_waddr = I_FP; end
            C_SETSP: begin rf_we = 1'b1; rf_waddr = I_SP; end
            C_SETAP: begin rf_we = 1'b1; rf_waddr = I_AP; rf_wdata = apn_q; end
            C_SETPC: begin
                rf_we    = 1'b1;
                rf_waddr = I_PC;
                rf_wdata = target_q + DW'(PC_ENTRY_SKIP);
                done     = 1'b1;
            end
            R_MASK:  begin mem_req = 1'b1; mem_addr = sp; end
            R_AP:    begin mem_req = 1'b1; mem_addr = sp; rf_we = mem_ack; rf_waddr = I_AP; rf_wdata = mem_rdata; end
            R_FP:    begin mem_req = 1'b1; mem_addr = sp; rf_we = mem_ack; rf_waddr = I_FP; rf_wdata = mem_rdata; end
            R_PC:    begin mem_req = 1'b1; mem_addr = sp; rf_we = mem_ack; rf_waddr = I_PC; rf_wdata = mem_rdata; end
            R_REGS:  begin mem_req = 1'b1; mem_addr = sp; rf_we = mem_ack; rf_waddr = lo_idx; rf_wdata = mem_rdata; end
            R_ARGC:  begin mem_req = 1'b1; mem_addr = sp; end
            R_SETSP: begin rf_we = 1'b1; rf_waddr = I_SP; done = 1'b1; end
            default: ;
        endcase
    end

    // R1: an idle block neither touches memory nor writes registers
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !done));

    // R10: request, direction and address stay put until acknowledged
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: back-to-back pushes step down by one word
    p_push_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
            (!(mem_req && mem_we) || mem_addr == $past(mem_addr) - DW'(4)));

    // R7: back-to-back pops step up by one word, and a return never writes memory
    p_pop_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
            (!mem_req || (!mem_we && mem_addr == $past(mem_addr) + DW'(4))));

    // R5: registers picked for saving come from below the pointer group
    p_save_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_REGS) |-> (int'(rf_raddr) < SAVE_LIMIT));

    // R11: done lasts one cycle and is followed by idle
    p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/test_frame_seq.sv
`timescale 1ns/1ps
module test_frame_seq;

    localparam int DW = 32;
    localparam int NREG = 16;
    localparam int ARGC_W = 8;
    localparam logic [31:0] S = 32'h0000_0F00;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, call_go, ret_go, busy, done;
    logic [ARGC_W-1:0] call_argc;
    logic [DW-1:0] call_target;
    logic [NREG-1:0] entry_mask;
    logic mem_req, mem_we, mem_ack, rf_we;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [3:0] rf_raddr, rf_waddr;

    logic [31:0] mem [0:1023];
    logic [31:0] rf [0:15];
    logic tb_we;
    logic [3:0] tb_wa;
    logic [31:0] tb_wd;
    int stall;
    int waitc;
    int acc_cnt;
    logic acc_clr;
    int nchk, nerr;

    frame_seq i_frame_seq (
        .clk(clk), .rst_n(rst_n), .call_go(call_go), .ret_go(ret_go),
        .call_argc(call_argc), .call_target(call_target), .entry_mask(entry_mask),
        .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign mem_rdata = mem[mem_addr[11:2]];
    assign rf_rdata  = rf[rf_raddr];

    always @(posedge clk) begin
        if (!mem_req || mem_ack) begin
            mem_ack <= 1'b0;
            waitc   <= 0;
        end else if (waitc >= stall) begin
            mem_ack <= 1'b1;
        end else begin
            waitc <= waitc + 1;
        end
        if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
        if (acc_clr) acc_cnt <= 0;
        else if (mem_req && mem_ack) acc_cnt <= acc_cnt + 1;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        else if (tb_we) rf[tb_wa] <= tb_wd;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_reg(input int i, input logic [31:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = 4'(i); tb_wd = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    // runs one sequence; returns whether busy stayed high and done came once
    task automatic run_op(input bit is_ret, input bit poke, output bit busy_ok);
        int n;
        busy_ok = 1'b1;
        @(negedge clk);
        if (is_ret) ret_go = 1'b1; else call_go = 1'b1;
        acc_clr = 1'b1;
        @(posedge clk);
        #1;
        call_go = 1'b0; ret_go = 1'b0; acc_clr = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            call_go = 1'b0; ret_go = 1'b0;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (poke && n == 2) begin
                if (is_ret) call_go = 1'b1; else ret_go = 1'b1;
            end
            n++;
            if (n > 400) begin
                check(1'b0, "R11 timeout", 32'(n), 32'd0);
                break;
            end
        end
        @(posedge clk);
        #1;
        if (busy) busy_ok = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        nerr++;
        $display("FAIL watchdog R11 actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] orig [0:15];
        logic [15:0] m, em;
        logic [31:0] a, fpx;
        int nsel, argc;
        bit ok, bok;
        nchk = 0; nerr = 0;
        rst_n = 1'b0; call_go = 1'b0; ret_go = 1'b0;
        call_argc = '0; call_target = '0; entry_mask = '0;
        tb_we = 1'b0; tb_wa = '0; tb_wd = '0; acc_clr = 1'b1; stall = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !rf_we && !done, "R1 in reset", {busy, mem_req, rf_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        acc_clr = 1'b0;
        check(!busy && !mem_req && !rf_we && !done, "R1 after reset", {busy, mem_req, rf_we, done}, 0);

        for (int k = 0; k < 70; k++) begin
            if (k < 64) m = 16'(k * 16'h0A5B) ^ 16'(k << 12);
            else case (k)
                64: m = 16'h0000;
                65: m = 16'hFFFF;
                66: m = 16'hF000;
                67: m = 16'h0FFF;
                68: m = 16'h0001;
                default: m = 16'h0800;
            endcase
            em = m & 16'h0FFF;
            nsel = $countones(em);
            argc = k % 6;
            stall = k % 3;
            for (int i = 0; i < 16; i++) orig[i] = 32'hA000_0000 + 32'(i * 32'h0101) + 32'(k << 16);
            orig[12] = S + 32'h40;
            orig[13] = S + 32'h80;
            orig[14] = S;
            orig[15] = 32'h0000_4000 + 32'(k * 8);
            for (int i = 0; i < 16; i++) set_reg(i, orig[i]);
            call_argc = 8'(argc);
            call_target = 32'h2000_0000 + 32'(k * 16);
            entry_mask = m;

            run_op(1'b0, (k % 5) == 0, bok);
            check(bok, "R11 call busy/done", {31'd0, bok}, 1);
            check(acc_cnt == nsel + 5, "R10 call access count", 32'(acc_cnt), 32'(nsel + 5));
            check(rd(S - 4) == 32'(argc) && rf[12] == S - 4, "R2 argc slot / new AP", rf[12], S - 4);
            ok = 1'b1;
            a = S - 8;
            for (int i = 11; i >= 0; i--) begin
                if (em[i]) begin
                    if (rd(a) != orig[i]) ok = 1'b0;
                    a = a - 4;
                end
            end
            check(ok, "R3 saved register order", {16'd0, em}, 32'(nsel));
            check(rd(a) == orig[15] && rd(a - 4) == orig[13] && rd(a - 8) == orig[12],
                  "R4 old PC/FP/AP slots", rd(a), orig[15]);
            check(rd(a - 12) == {16'd0, em}, "R5 stored mask word", rd(a - 12), {16'd0, em});
            fpx = a - 12;
            check(rf[13] == fpx && rf[14] == fpx, "R6 FP and SP at mask word", rf[14], fpx);
            check(rf[15] == call_target + 2, "R6 PC = target+2", rf[15], call_target + 2);

            for (int i = 0; i < 12; i++) set_reg(i, ~orig[i]);
            run_op(1'b1, (k % 7) == 3, bok);
            check(bok, "R11 return busy/done", {31'd0, bok}, 1);
            check(acc_cnt == nsel + 5, "R10 return access count", 32'(acc_cnt), 32'(nsel + 5));
            ok = 1'b1;
            for (int i = 0; i < 12; i++) if (em[i] && rf[i] != orig[i]) ok = 1'b0;
            check(ok && rf[12] == orig[12] && rf[13] == orig[13] && rf[15] == orig[15],
                  "R7 restored registers and pointers", rf[15], orig[15]);
            ok = 1'b1;
            for (int i = 0; i < 12; i++) if (!em[i] && rf[i] != ~orig[i]) ok = 1'b0;
            check(ok, "R8 unmasked registers untouched", {16'd0, em}, {16'd0, em});
            check(rf[14] == S + 32'(4 * argc), "R9 final SP", rf[14], S + 32'(4 * argc));
            check(!busy && !mem_req && !rf_we, "R1 idle after return", {busy, mem_req, rf_we}, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule